// File: doc/BRIEF.md
# Descriptor Chain Fetch Channel

This block is one work channel of a command-driven accelerator. Software hands it the word address of a work descriptor by pulsing a pointer write. The channel reads the whole descriptor as one burst over a memory read port and holds it in a local buffer. It then walks the descriptor's length/pointer pairs in slot order. For every pair with a non-zero length it offers one transfer request to an execution-unit port, tagged with the mode bits from the header, and waits for the unit to report that it has finished. When the pairs are used up, the channel may report completion, and then it either follows the link word to the next descriptor or goes back to idle.

A descriptor is sixteen consecutive words. Completion is reported either as a one-cycle interrupt pulse or by writing the header back to its own address with a done bit set. Two configuration inputs choose between these forms and choose whether reporting happens after every descriptor or only after the last one in a chain. If a read response carries an error, the channel records the address of the descriptor it was fetching and halts. The next accepted pointer write restarts it.

All three streaming ports use valid/ready. A request holds valid, and all of its payload, steady until the cycle in which ready is seen high. The read-response port is ready only while a burst is being collected. Pointer writes, configuration, interrupt and status are plain level or pulse signals.

Top module: `desc_chan`

## Requirements
- R1: After reset the channel is idle: busy, halted, irq, rd_req_valid, xfer_valid, wb_valid, stat_err and stat_ign are all 0.
- R2: A pointer write while idle or halted starts a burst read request of 16 words at the written address. rd_req_valid and rd_req_addr stay steady until rd_req_ready is seen.
- R3: Descriptor layout, as word offsets from the base: 0 is the header, 1+2i is the length of pair i, 2+2i is the pointer of pair i (i = 0..6), and 15 is the link. Transfers are issued in increasing pair order, with xfer_mode = header[7:0], xfer_slot = i, and xfer_len and xfer_ptr taken from the pair.
- R4: A pair whose length is zero produces no transfer. A descriptor whose lengths are all zero still completes and is still reported.
- R5: xfer_valid and its payload stay steady until xfer_ready. After a transfer is accepted, the next one is not offered before an xfer_done pulse.
- R6: After the last pair, a non-zero link starts a new descriptor fetch at the link address. A zero link ends the chain and busy returns to 0.
- R7: With cfg_chain_only = 0, completion is reported once per descriptor. With cfg_chain_only = 1, it is reported only for the descriptor whose link is zero.
- R8: With cfg_writeback = 0, a report is a one-cycle irq pulse. With cfg_writeback = 1, a report is a write of the header, with bit 31 set and every other bit unchanged, to the descriptor's base address, and irq stays 0.
- R9: A read response with rd_rsp_err set stops the channel. halted and stat_err go to 1, stat_err_addr holds the address of the descriptor being fetched, and no further transfer is issued. The next pointer write clears stat_err and restarts the channel.
- R10: A pointer write while busy is ignored and sets stat_ign. stat_ign stays set until the next accepted pointer write.
- R11: At most one of rd_req_valid, xfer_valid, wb_valid and irq is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_addr | input | AW | Descriptor word address to start from |
| cfg_chain_only | input | 1 | 1: report only at the end of the chain |
| cfg_writeback | input | 1 | 1: report by header write-back, 0: by irq |
| rd_req_valid | output | 1 | Burst read request valid |
| rd_req_ready | input | 1 | Burst read request accepted |
| rd_req_addr | output | AW | Burst start address (16 words) |
| rd_rsp_valid | input | 1 | Read data word valid |
| rd_rsp_ready | output | 1 | Channel is collecting a burst |
| rd_rsp_data | input | DW | Read data word |
| rd_rsp_err | input | 1 | Error response for this word |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_mode | output | MODE_W | Mode bits from the header |
| xfer_slot | output | PW | Pair index 0..6 |
| xfer_len | output | DW | Pair length |
| xfer_ptr | output | AW | Pair pointer |
| xfer_done | input | 1 | Unit finished the accepted transfer |
| wb_valid | output | 1 | Header write-back valid |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | AW | Write-back address (descriptor base) |
| wb_data | output | DW | Header with done bit set |
| irq | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Channel is working on a chain |
| halted | output | 1 | Channel stopped after an error |
| stat_err | output | 1 | Error was recorded |
| stat_err_addr | output | AW | Address of the failed descriptor fetch |
| stat_ign | output | 1 | A pointer write was ignored |

## Verification
A pointer write and the end of a chain can land in the same cycle. On the cycle where the final completion is reported, the channel is still busy, and on the next edge it drops back to idle. The bench waits until it sees irq high and drives a pointer write in that same cycle. It then judges that the write was ignored: stat_ign must be set, no new read request may appear, and the channel must settle in idle. The bench also throttles xfer_ready in some runs, so that back-pressure and the wait for xfer_done overlap.

// File: rtl/desc_pkg.sv
package desc_pkg;
  localparam int NPAIR      = 7;
  localparam int DESC_WORDS = 2 * NPAIR + 2;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_RECV, S_SCAN, S_XFER, S_WAIT, S_NOTE, S_WB, S_HALT
  } chan_st_t;
endpackage

// File: rtl/desc_store.sv
module desc_store
  import desc_pkg::*;
#(
  parameter int DW = 32,
  localparam int IW = $clog2(DESC_WORDS)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [DW-1:0]             wr_data,
  output logic [DW-1:0]             header,
  output logic [NPAIR-1:0][DW-1:0]  lens,
  output logic [NPAIR-1:0][DW-1:0]  ptrs,
  output logic [DW-1:0]             link
);
  logic [DW-1:0] words [DESC_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  assign header = words[0];
  assign link   = words[DESC_WORDS-1];

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign lens[i] = words[1 + 2*i];
    assign ptrs[i] = words[2 + 2*i];
  end
endmodule

// File: rtl/pair_pick.sv
module pair_pick
  import desc_pkg::*;
#(
  parameter int DW = 32,
  localparam int PW = $clog2(NPAIR + 1)
) (
  input  logic [NPAIR-1:0][DW-1:0] lens,
  input  logic [PW-1:0]            from,
  output logic                     found,
  output logic [PW-1:0]            sel
);
  logic [NPAIR-1:0] cand;

  for (genvar i = 0; i < NPAIR; i++) begin : g_cand
    assign cand[i] = (lens[i] != '0) && (PW'(i) >= from);
  end

  always_comb begin
    found = |cand;
    sel   = '0;
    for (int i = NPAIR - 1; i >= 0; i--) begin
      if (cand[i]) sel = PW'(i);
    end
  end
endmodule

// File: rtl/desc_chan.sv
module desc_chan
  import desc_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int MODE_W   = 8,
  parameter int DONE_BIT = 31,
  localparam int PW      = $clog2(NPAIR + 1),
  localparam int IW      = $clog2(DESC_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [AW-1:0]     ptr_addr,
  input  logic              cfg_chain_only,
  input  logic              cfg_writeback,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DW-1:0]     rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [MODE_W-1:0] xfer_mode,
  output logic [PW-1:0]     xfer_slot,
  output logic [DW-1:0]     xfer_len,
  output logic [AW-1:0]     xfer_ptr,
  input  logic              xfer_done,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [AW-1:0]     wb_addr,
  output logic [DW-1:0]     wb_data,
  output logic              irq,
  output logic              busy,
  output logic              halted,
  output logic              stat_err,
  output logic [AW-1:0]     stat_err_addr,
  output logic              stat_ign
);
  chan_st_t                state;
  logic [AW-1:0]           base;
  logic [IW-1:0]           widx;
  logic [PW-1:0]           pidx;
  logic [PW-1:0]           cur;

  logic [DW-1:0]           hdr;
  logic [NPAIR-1:0][DW-1:0] lens;
  logic [NPAIR-1:0][DW-1:0] ptrs;
  logic [DW-1:0]           link;
  logic                    found;
  logic [PW-1:0]           pick;
  logic                    store_wr;
  logic                    last_desc;
  logic                    report;

  desc_store #(.DW(DW)) u_store (
    .clk     (clk),
    .wr_en   (store_wr),
    .wr_idx  (widx),
    .wr_data (rd_rsp_data),
    .header  (hdr),
    .lens    (lens),
    .ptrs    (ptrs),
    .link    (link)
  );

  pair_pick #(.DW(DW)) u_pick (
    .lens  (lens),
    .from  (pidx),
    .found (found),
    .sel   (pick)
  );

  assign store_wr  = (state == S_RECV) && rd_rsp_valid && !rd_rsp_err;
  assign last_desc = (link == '0);
  assign report    = !cfg_chain_only || last_desc;

  assign busy   = (state != S_IDLE) && (state != S_HALT);
  assign halted = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      base          <= '0;
      widx          <= '0;
      pidx          <= '0;
      cur           <= '0;
      stat_err      <= 1'b0;
      stat_err_addr <= '0;
      stat_ign      <= 1'b0;
    end else begin
      if (ptr_wr) begin
        if (busy) begin
          stat_ign <= 1'b1;
        end else begin
          stat_ign <= 1'b0;
          stat_err <= 1'b0;
          base     <= ptr_addr;
          state    <= S_REQ;
        end
      end
      case (state)
        S_REQ: if (rd_req_ready) begin
          widx  <= '0;
          state <= S_RECV;
        end
        S_RECV: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            stat_err      <= 1'b1;
            stat_err_addr <= base;
            state         <= S_HALT;
          end else begin
            widx <= widx + 1'b1;
            if (widx == IW'(DESC_WORDS - 1)) begin
              pidx  <= '0;
              state <= S_SCAN;
            end
          end
        end
        S_SCAN: begin
          if (found) begin
            cur   <= pick;
            state <= S_XFER;
          end else begin
            state <= S_NOTE;
          end
        end
        S_XFER: if (xfer_ready) state <= S_WAIT;
        S_WAIT: if (xfer_done) begin
          pidx  <= cur + 1'b1;
          state <= S_SCAN;
        end
        S_NOTE, S_WB: begin
          if (state == S_NOTE && report && cfg_writeback) begin
            state <= S_WB;
          end else if (state == S_NOTE || wb_ready) begin
            if (last_desc) begin
              state <= S_IDLE;
            end else begin
              base  <= link[AW-1:0];
              state <= S_REQ;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_req_valid = (state == S_REQ);
  assign rd_req_addr  = base;
  assign rd_rsp_ready = (state == S_RECV);

  assign xfer_valid = (state == S_XFER);
  assign xfer_mode  = hdr[MODE_W-1:0];
  assign xfer_slot  = cur;
  assign xfer_len   = lens[cur];
  assign xfer_ptr   = ptrs[cur][AW-1:0];

  assign wb_valid = (state == S_WB);
  assign wb_addr  = base;
  assign wb_data  = hdr | (DW'(1) << DONE_BIT);

  assign irq = (state == S_NOTE) && report && !cfg_writeback;
endmodule

// File: rtl/desc_chan_chk.sv
module desc_chan_chk #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int MODE_W   = 8,
  parameter int DONE_BIT = 31,
  parameter int PW       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ptr_wr,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [AW-1:0]     rd_req_addr,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [PW-1:0]     xfer_slot,
  input logic [DW-1:0]     xfer_len,
  input logic [AW-1:0]     xfer_ptr,
  input logic              wb_valid,
  input logic [DW-1:0]     wb_data,
  input logic              irq,
  input logic              busy,
  input logic              halted,
  input logic              stat_err,
  input logic              stat_ign
);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r4_no_empty_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_len != '0);

  a_r5_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_slot)
      && $stable(xfer_len) && $stable(xfer_ptr));

  a_r8_wb_done_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_data[DONE_BIT]);

  a_r9_halt_flag: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> stat_err && !busy);

  a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr && busy |=> stat_ign);

  a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, xfer_valid, wb_valid, irq}));
endmodule

bind desc_chan desc_chan_chk #(
  .AW(AW), .DW(DW), .MODE_W(MODE_W), .DONE_BIT(DONE_BIT), .PW(PW)
) u_chk (.*);

// File: tb/sim_desc_chan.sv
module sim_desc_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr = 1'b0;
  logic [31:0] ptr_addr = '0;
  logic        cfg_chain_only = 1'b0;
  logic        cfg_writeback = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b1;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic        rd_rsp_err = 1'b0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [7:0]  xfer_mode;
  logic [2:0]  xfer_slot;
  logic [31:0] xfer_len;
  logic [31:0] xfer_ptr;
  logic        xfer_done = 1'b0;
  logic        wb_valid;
  logic        wb_ready = 1'b1;
  logic [31:0] wb_addr;
  logic [31:0] wb_data;
  logic        irq;
  logic        busy;
  logic        halted;
  logic        stat_err;
  logic [31:0] stat_err_addr;
  logic        stat_ign;

  desc_chan u0 (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [256];
  logic [74:0] expq [$];
  int req_log [$];
  int irq_cnt = 0, wb_cnt = 0, xfer_cnt = 0, multi_cnt = 0;
  int err_base = -1;
  bit stall_mode = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: lays out a descriptor and pushes the transfers it should yield
  task automatic put_desc(input int b, input logic [31:0] hdr, input int seed,
                          input int link, input bit expect_it);
    mem[b] = hdr;
    for (int i = 0; i < 7; i++) begin
      int l;
      l = seed[i] ? (b + i + 1) * 3 : 0;
      mem[b + 1 + 2*i] = l;
      mem[b + 2 + 2*i] = b * 100 + i;
      if (expect_it && l != 0)
        expq.push_back({hdr[7:0], 3'(i), 32'(l), 32'(b * 100 + i)});
    end
    mem[b + 15] = link;
  endtask

  // memory read responder
  initial begin
    int pending = 0, ridx = 0, rbase = 0;
    forever begin
      @(negedge clk);
      if (pending > 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[(rbase + ridx) & 255];
        rd_rsp_err   = (rbase == err_base) && (ridx == 3);
        ridx++;
        pending--;
        if (rd_rsp_err) pending = 0;
      end else begin
        rd_rsp_valid = 1'b0;
        rd_rsp_err   = 1'b0;
      end
      if (rd_req_valid && pending == 0) begin
        req_log.push_back(int'(rd_req_addr));
        pending = 16;
        ridx    = 0;
        rbase   = int'(rd_req_addr);
      end
    end
  end

  // transfer engine and scoreboard monitor
  initial begin
    int hold = 0, dd = 0;
    logic [74:0] got, exp_item;
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (dd > 0) begin
        dd--;
        if (dd == 0) xfer_done = 1'b1;
      end
      if (xfer_valid) begin
        if (hold > 0) begin
          hold--;
          xfer_ready = 1'b0;
        end else begin
          xfer_ready = 1'b1;
          xfer_cnt++;
          got = {xfer_mode, xfer_slot, xfer_len, xfer_ptr};
          checks++;
          if (expq.size() == 0) begin
            errors++;
            $display("FAIL R3 unexpected transfer actual=%0h expected=none", got);
          end else begin
            exp_item = expq.pop_front();
            if (got !== exp_item) begin
              errors++;
              $display("FAIL R3 transfer actual=%0h expected=%0h", got, exp_item);
            end
          end
          dd   = 3;
          hold = stall_mode ? 2 : 0;
        end
      end else begin
        xfer_ready = 1'b0;
      end
    end
  end

  // write-back sink, irq counter, one-action monitor
  initial begin
    forever begin
      @(negedge clk);
      if (wb_valid) begin
        mem[wb_addr & 255] = wb_data;
        wb_cnt++;
      end
      if (irq) irq_cnt++;
      if (32'(rd_req_valid) + 32'(xfer_valid) + 32'(wb_valid) + 32'(irq) > 1)
        multi_cnt++;
    end
  end

  task automatic clear_counts();
    irq_cnt = 0; wb_cnt = 0; xfer_cnt = 0;
    req_log.delete();
  endtask

  task automatic kick(input int a);
    @(negedge clk);
    ptr_wr = 1'b1;
    ptr_addr = a;
    @(negedge clk);
    ptr_wr = 1'b0;
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_log(input string tag, input int a0, input int a1, input int a2, input int n);
    chk({tag, " request count"}, req_log.size(), n);
    if (n > 0 && req_log.size() > 0) chk({tag, " addr0"}, req_log[0], a0);
    if (n > 1 && req_log.size() > 1) chk({tag, " addr1"}, req_log[1], a1);
    if (n > 2 && req_log.size() > 2) chk({tag, " addr2"}, req_log[2], a2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 outputs", {rd_req_valid, xfer_valid, wb_valid, irq, halted}, 0);
    chk("R1 status", {stat_err, stat_ign}, 0);

    // R2 R3 R4 R6 single descriptor with gaps, irq per descriptor
    clear_counts();
    put_desc(16, 32'h0000_00A5, 7'b1010110, 0, 1);
    kick(16);
    drain();
    chk_log("R2", 16, 0, 0, 1);
    chk("R4 transfer count", xfer_cnt, 4);
    chk("R3 scoreboard empty", expq.size(), 0);
    chk("R6 idle after zero link", busy, 0);
    chk("R8 irq once", irq_cnt, 1);

    // R5 R6 R7 three-descriptor chain, stalled unit, per-descriptor report
    clear_counts();
    stall_mode = 1;
    put_desc(32, 32'h0000_0011, 7'b1111111, 48, 1);
    put_desc(48, 32'h0000_0022, 7'b0000001, 64, 1);
    put_desc(64, 32'h0000_0033, 7'b1000000, 0, 1);
    kick(32);
    drain();
    chk_log("R6 link follow", 32, 48, 64, 3);
    chk("R5 all transfers under back-pressure", xfer_cnt, 9);
    chk("R5 scoreboard empty", expq.size(), 0);
    chk("R7 per-descriptor irq", irq_cnt, 3);
    stall_mode = 0;

    // R7 chain-only report
    clear_counts();
    cfg_chain_only = 1'b1;
    put_desc(32, 32'h0000_0011, 7'b0101010, 48, 1);
    put_desc(48, 32'h0000_0022, 7'b0000011, 64, 1);
    put_desc(64, 32'h0000_0033, 7'b0010000, 0, 1);
    kick(32);
    drain();
    chk("R7 chain-only irq", irq_cnt, 1);
    chk("R7 scoreboard empty", expq.size(), 0);
    cfg_chain_only = 1'b0;

    // R8 write-back per descriptor
    clear_counts();
    cfg_writeback = 1'b1;
    put_desc(80, 32'h0000_1234, 7'b0000101, 96, 1);
    put_desc(96, 32'h0ABC_0056, 7'b1100000, 0, 1);
    kick(80);
    drain();
    chk("R8 writeback count", wb_cnt, 2);
    chk("R8 header 80", mem[80], 32'h8000_1234);
    chk("R8 header 96", mem[96], 32'h8ABC_0056);
    chk("R8 no irq in writeback", irq_cnt, 0);

    // R7 R8 write-back only at chain end
    clear_counts();
    cfg_chain_only = 1'b1;
    put_desc(112, 32'h0000_0077, 7'b0000001, 128, 1);
    put_desc(128, 32'h0000_0088, 7'b0000010, 0, 1);
    kick(112);
    drain();
    chk("R7 writeback once", wb_cnt, 1);
    chk("R7 first header untouched", mem[112], 32'h0000_0077);
    chk("R8 last header done", mem[128], 32'h8000_0088);
    cfg_chain_only = 1'b0;
    cfg_writeback  = 1'b0;

    // R4 all-empty descriptor
    clear_counts();
    put_desc(144, 32'h0000_0099, 0, 0, 1);
    kick(144);
    drain();
    chk("R4 empty no transfers", xfer_cnt, 0);
    chk("R4 empty still reported", irq_cnt, 1);

    // R10 pointer write while busy
    clear_counts();
    put_desc(160, 32'h0000_00C1, 7'b1111111, 0, 1);
    put_desc(176, 32'h0000_00C2, 7'b1111111, 0, 0);
    kick(160);
    repeat (5) @(negedge clk);
    ptr_wr = 1'b1; ptr_addr = 176;
    @(negedge clk);
    ptr_wr = 1'b0;
    drain();
    chk("R10 flag set", stat_ign, 1);
    chk_log("R10 no extra fetch", 160, 0, 0, 1);
    chk("R10 scoreboard empty", expq.size(), 0);
    clear_counts();
    put_desc(176, 32'h0000_00C2, 7'b0000001, 0, 1);
    kick(176);
    drain();
    chk("R10 flag cleared by accepted write", stat_ign, 0);
    chk("R10 second run transfers", xfer_cnt, 1);

    // R10 pointer write in the completion cycle
    clear_counts();
    put_desc(192, 32'h0000_00D0, 7'b0000100, 0, 1);
    kick(192);
    while (!irq) @(negedge clk);
    ptr_wr = 1'b1; ptr_addr = 16;
    @(negedge clk);
    ptr_wr = 1'b0;
    drain();
    chk("R10 same-cycle write ignored", stat_ign, 1);
    chk_log("R10 same-cycle no fetch", 192, 0, 0, 1);
    chk("R10 same-cycle idle", busy, 0);

    // R9 error response halts
    clear_counts();
    err_base = 224;
    put_desc(208, 32'h0000_00E0, 7'b0011000, 224, 1);
    put_desc(224, 32'h0000_00E1, 7'b1111111, 0, 0);
    kick(208);
    drain();
    chk("R9 halted", halted, 1);
    chk("R9 error flag", stat_err, 1);
    chk("R9 error address", stat_err_addr, 224);
    chk("R9 no transfers after error", xfer_cnt, 2);
    chk("R9 scoreboard empty", expq.size(), 0);
    err_base = -1;
    clear_counts();
    put_desc(224, 32'h0000_00E1, 7'b0000011, 0, 1);
    kick(224);
    drain();
    chk("R9 restart clears error", stat_err, 0);
    chk("R9 restart not halted", halted, 0);
    chk("R9 restart transfers", xfer_cnt, 2);

    chk("R11 one action per cycle", multi_cnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule